// File: doc/BRIEF.md
# Texture-Pipe Ganging Fragment Dispatcher

This block takes pixel fragments and places them onto four parallel pixel pipelines. Each pipeline has two texture lookup slots per cycle. Every fragment carries an identifier and a count of the textures it needs, from one to four.

A fragment that needs one or two textures takes a single pipeline. In ganged mode, a fragment that needs three or four textures takes an aligned pair of pipelines in the same cycle. The lower pipeline of the pair serves texture slots 0 and 1, and the upper pipeline serves the remaining slots, so the fragment finishes in one pass. In legacy mode, the same fragment uses one pipeline twice: slots 0–1 go in the first cycle and slots 2–3 in the next cycle. Input acceptance is frozen during that second pass.

Upstream presents up to four fragments per cycle on ordered lanes, each lane with its own valid and ready. The block accepts a prefix of those lanes in strict order. Each placement reaches the registered pipeline outputs one cycle after the edge that accepts it. Two counts, the fragments issued and the pipelines busy in that output cycle, let a consumer measure throughput.

Top module: `frag_dispatch`

## Requirements
- R1: While reset is held, and until the synchronised release, every pipe strobe is low, both counts are zero and every lane ready is low.
- R2: A texture count field (3 bits) of 0 is handled as 1, and a value of 5, 6 or 7 is handled as 4.
- R3: A fragment needing one or two textures occupies one pipe with slot base 0, slot count equal to its texture count, and gang flag low.
- R4: In ganged mode (gang_en=1), a fragment needing three or four textures occupies pipes 2q and 2q+1 in the same cycle, both with gang flag high and the same ID. The lower pipe has base 0 and count 2. The upper pipe has base 2 and count (textures − 2).
- R5: Lanes are served in order and fragments fill the lowest free pipe first. in_ready is a prefix of in_valid: an invalid lane, or a lane that does not fit, stops acceptance of itself and of every later lane that cycle.
- R6: If the next free pipe is odd when a pair is needed, the pair moves to the next even pipe and the odd pipe stays idle that cycle.
- R7: In legacy mode (gang_en=0), a three- or four-texture fragment takes one pipe with base 0, count 2 and gang flag low, and it is the last lane accepted that cycle.
- R8: In the cycle after a legacy first pass, all lane readies are low. Pipe 0 then issues the same ID with base 2, count (textures − 2) and gang flag low, and no other pipe issues.
- R9: Each placement appears on the pipe outputs for exactly one cycle, directly after the clock edge at which its lane was accepted (or at which its second pass was scheduled).
- R10: frag_cnt equals the number of distinct fragments on the pipes this output cycle, with a pair counted once, and busy_cnt equals the number of pipes issuing.
- R11: Four one- or two-texture fragments can issue in one cycle (frag_cnt=4, busy_cnt=4), and two ganged fragments can issue in one cycle (frag_cnt=2, busy_cnt=4).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gang_en | input | 1 | 1: pair pipes for 3–4 texture fragments; 0: two-pass legacy mode |
| in_valid | input | NUM_PIPES | Per-lane fragment valid, lane 0 oldest |
| in_ready | output | NUM_PIPES | Per-lane accept, always a prefix |
| in_id | input | NUM_PIPES*ID_W | Per-lane fragment ID |
| in_tex | input | NUM_PIPES*3 | Per-lane texture count |
| pipe_issue | output | NUM_PIPES | Per-pipe issue strobe |
| pipe_id | output | NUM_PIPES*ID_W | Per-pipe fragment ID |
| pipe_gang | output | NUM_PIPES | Pipe is half of a ganged pair |
| pipe_slot_base | output | NUM_PIPES*2 | First texture slot index served by the pipe |
| pipe_slot_num | output | NUM_PIPES*2 | Number of texture slots used (1 or 2) |
| frag_cnt | output | $clog2(NUM_PIPES+1) | Fragments issued this output cycle |
| busy_cnt | output | $clog2(NUM_PIPES+1) | Pipes issuing this output cycle |

## Verification
The bench builds the block with its defaults, NUM_PIPES=4 and ID_W=8. With four pipes, both aligned pair positions (0–1 and 2–3) can be used, and a pair can be pushed past an idle odd pipe. Both full-throughput mixes (four singles, or two pairs) fit in one cycle. The 3-bit count field lets stimulus reach the clamp values 0 and 5–7. An 8-bit ID keeps fragments distinct across a long random run, so a swapped or duplicated placement shows up as a wrong ID on a specific pipe.

// File: rtl/frag_dispatch_pkg.sv
package frag_dispatch_pkg;

  localparam int TEX_W     = 3;
  localparam int SLOT_IDXW = 2;

  typedef struct packed {
    logic                 vld;
    logic                 gang;
    logic                 hi;    // upper half of a ganged pair
    logic [SLOT_IDXW-1:0] base;
    logic [SLOT_IDXW-1:0] num;
  } pipe_slot_t;

  function automatic logic [TEX_W-1:0] clamp_tex(input logic [TEX_W-1:0] raw);
    if (raw == 3'd0) return 3'd1;
    if (raw > 3'd4)  return 3'd4;
    return raw;
  endfunction

endpackage

// File: rtl/frag_alloc.sv
module frag_alloc
  import frag_dispatch_pkg::*;
#(
  parameter int NUM_PIPES = 4,
  parameter int ID_W      = 8
) (
  input  logic                             run,
  input  logic                             gang_en,
  input  logic                             pend,
  input  logic [ID_W-1:0]                  pend_id,
  input  logic [SLOT_IDXW-1:0]             pend_num,
  input  logic [NUM_PIPES-1:0]             in_valid,
  input  logic [NUM_PIPES*ID_W-1:0]        in_id,
  input  logic [NUM_PIPES*TEX_W-1:0]       in_tex,
  output logic [NUM_PIPES-1:0]             in_ready,
  output pipe_slot_t [NUM_PIPES-1:0]       slot_nxt,
  output logic [NUM_PIPES-1:0][ID_W-1:0]   id_nxt,
  output logic                             pend_set,
  output logic [ID_W-1:0]                  pend_id_nxt,
  output logic [SLOT_IDXW-1:0]             pend_num_nxt
);

  always_comb begin
    int               free;
    int               pair;
    logic             stop;
    logic [TEX_W-1:0] cnt;
    logic [ID_W-1:0]  fid;
    free         = 0;
    pair         = 0;
    stop         = !run;
    cnt          = '0;
    fid          = '0;
    in_ready     = '0;
    slot_nxt     = '0;
    id_nxt       = '0;
    pend_set     = 1'b0;
    pend_id_nxt  = '0;
    pend_num_nxt = '0;
    if (pend) begin
      slot_nxt[0] = '{vld: 1'b1, gang: 1'b0, hi: 1'b0, base: 2'd2, num: pend_num};
      id_nxt[0]   = pend_id;
      stop        = 1'b1;
    end
    for (int k = 0; k < NUM_PIPES; k++) begin
      cnt  = clamp_tex(in_tex[k*TEX_W +: TEX_W]);
      fid  = in_id[k*ID_W +: ID_W];
      pair = free + (free % 2);
      if (stop || !in_valid[k]) begin
        stop = 1'b1;
      end else if (cnt <= 3'd2 || !gang_en) begin
        if (free >= NUM_PIPES) begin
          stop = 1'b1;
        end else begin
          for (int p = 0; p < NUM_PIPES; p++) begin
            if (p == free) begin
              slot_nxt[p] = '{vld: 1'b1, gang: 1'b0, hi: 1'b0, base: 2'd0,
                              num: (cnt > 3'd2) ? 2'd2 : cnt[1:0]};
              id_nxt[p]   = fid;
            end
          end
          in_ready[k] = 1'b1;
          free        = free + 1;
          if (cnt > 3'd2) begin
            pend_set     = 1'b1;
            pend_id_nxt  = fid;
            pend_num_nxt = 2'(cnt - 3'd2);
            stop         = 1'b1;
          end
        end
      end else begin
        if (pair + 1 >= NUM_PIPES) begin
          stop = 1'b1;
        end else begin
          for (int p = 0; p < NUM_PIPES; p++) begin
            if (p == pair) begin
              slot_nxt[p] = '{vld: 1'b1, gang: 1'b1, hi: 1'b0, base: 2'd0, num: 2'd2};
              id_nxt[p]   = fid;
            end else if (p == pair + 1) begin
              slot_nxt[p] = '{vld: 1'b1, gang: 1'b1, hi: 1'b1, base: 2'd2,
                              num: 2'(cnt - 3'd2)};
              id_nxt[p]   = fid;
            end
          end
          in_ready[k] = 1'b1;
          free        = pair + 2;
        end
      end
    end
  end

  // R5
  ready_valid_chk: assert final (!run || (in_ready & ~in_valid) == '0);

endmodule

// File: rtl/pass2_ctl.sv
module pass2_ctl
  import frag_dispatch_pkg::*;
#(
  parameter int ID_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pend_set,
  input  logic [ID_W-1:0]      pend_id_nxt,
  input  logic [SLOT_IDXW-1:0] pend_num_nxt,
  output logic                 pend_q,
  output logic [ID_W-1:0]      pend_id_q,
  output logic [SLOT_IDXW-1:0] pend_num_q
);

  logic                 pend_d;
  logic                 info_en;
  logic [ID_W-1:0]      pend_id_d;
  logic [SLOT_IDXW-1:0] pend_num_d;

  always_comb begin
    pend_d     = pend_set;
    info_en    = pend_set;
    pend_id_d  = pend_id_nxt;
    pend_num_d = pend_num_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q     <= 1'b0;
      pend_id_q  <= '0;
      pend_num_q <= '0;
    end else begin
      pend_q <= pend_d;
      if (info_en) begin
        pend_id_q  <= pend_id_d;
        pend_num_q <= pend_num_d;
      end
    end
  end

  // R8
  pass2_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |=> !pend_q);

  // R8
  pass2_num_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> (pend_num_q == 2'd1 || pend_num_q == 2'd2));

endmodule

// File: rtl/pipe_out_reg.sv
module pipe_out_reg
  import frag_dispatch_pkg::*;
#(
  parameter int NUM_PIPES = 4,
  parameter int ID_W      = 8,
  localparam int CNT_W    = $clog2(NUM_PIPES + 1)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  pipe_slot_t [NUM_PIPES-1:0]     slot_nxt,
  input  logic [NUM_PIPES-1:0][ID_W-1:0] id_nxt,
  output pipe_slot_t [NUM_PIPES-1:0]     slot_q,
  output logic [NUM_PIPES-1:0][ID_W-1:0] id_q,
  output logic [CNT_W-1:0]               frag_cnt,
  output logic [CNT_W-1:0]               busy_cnt
);

  pipe_slot_t [NUM_PIPES-1:0]     slot_d;
  logic [NUM_PIPES-1:0][ID_W-1:0] id_d;

  always_comb begin
    slot_d = slot_nxt;
    id_d   = id_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= '0;
      id_q   <= '0;
    end else begin
      slot_q <= slot_d;
      id_q   <= id_d;
    end
  end

  always_comb begin
    frag_cnt = '0;
    busy_cnt = '0;
    for (int p = 0; p < NUM_PIPES; p++) begin
      busy_cnt = busy_cnt + CNT_W'(slot_q[p].vld);
      frag_cnt = frag_cnt + CNT_W'(slot_q[p].vld & ~slot_q[p].hi);
    end
  end

  // R10
  count_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frag_cnt <= busy_cnt);

  // R11
  frag_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    2 * frag_cnt >= busy_cnt);

endmodule

// File: rtl/frag_dispatch.sv
module frag_dispatch
  import frag_dispatch_pkg::*;
#(
  parameter int NUM_PIPES = 4,
  parameter int ID_W      = 8,
  localparam int CNT_W    = $clog2(NUM_PIPES + 1)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         gang_en,
  input  logic [NUM_PIPES-1:0]         in_valid,
  output logic [NUM_PIPES-1:0]         in_ready,
  input  logic [NUM_PIPES*ID_W-1:0]    in_id,
  input  logic [NUM_PIPES*TEX_W-1:0]   in_tex,
  output logic [NUM_PIPES-1:0]         pipe_issue,
  output logic [NUM_PIPES*ID_W-1:0]    pipe_id,
  output logic [NUM_PIPES-1:0]         pipe_gang,
  output logic [NUM_PIPES*2-1:0]       pipe_slot_base,
  output logic [NUM_PIPES*2-1:0]       pipe_slot_num,
  output logic [CNT_W-1:0]             frag_cnt,
  output logic [CNT_W-1:0]             busy_cnt
);

  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic                           pend_q;
  logic [ID_W-1:0]                pend_id_q;
  logic [SLOT_IDXW-1:0]           pend_num_q;
  logic                           pend_set;
  logic [ID_W-1:0]                pend_id_nxt;
  logic [SLOT_IDXW-1:0]           pend_num_nxt;
  pipe_slot_t [NUM_PIPES-1:0]     slot_nxt;
  pipe_slot_t [NUM_PIPES-1:0]     slot_q;
  logic [NUM_PIPES-1:0][ID_W-1:0] id_nxt;
  logic [NUM_PIPES-1:0][ID_W-1:0] id_q;

  frag_alloc #(.NUM_PIPES(NUM_PIPES), .ID_W(ID_W)) u_alloc (
    .run          (rst_sync_n),
    .gang_en      (gang_en),
    .pend         (pend_q),
    .pend_id      (pend_id_q),
    .pend_num     (pend_num_q),
    .in_valid     (in_valid),
    .in_id        (in_id),
    .in_tex       (in_tex),
    .in_ready     (in_ready),
    .slot_nxt     (slot_nxt),
    .id_nxt       (id_nxt),
    .pend_set     (pend_set),
    .pend_id_nxt  (pend_id_nxt),
    .pend_num_nxt (pend_num_nxt)
  );

  pass2_ctl #(.ID_W(ID_W)) u_pass2 (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .pend_set     (pend_set),
    .pend_id_nxt  (pend_id_nxt),
    .pend_num_nxt (pend_num_nxt),
    .pend_q       (pend_q),
    .pend_id_q    (pend_id_q),
    .pend_num_q   (pend_num_q)
  );

  pipe_out_reg #(.NUM_PIPES(NUM_PIPES), .ID_W(ID_W)) u_out (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .slot_nxt (slot_nxt),
    .id_nxt   (id_nxt),
    .slot_q   (slot_q),
    .id_q     (id_q),
    .frag_cnt (frag_cnt),
    .busy_cnt (busy_cnt)
  );

  assign pipe_id = id_q;

  for (genvar p = 0; p < NUM_PIPES; p++) begin : g_pipe
    assign pipe_issue[p]           = slot_q[p].vld;
    assign pipe_gang[p]            = slot_q[p].gang;
    assign pipe_slot_base[2*p +: 2] = slot_q[p].base;
    assign pipe_slot_num[2*p +: 2]  = slot_q[p].num;
  end

  for (genvar k = 1; k < NUM_PIPES; k++) begin : g_prefix
    // R5
    ready_prefix_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
      in_ready[k] |-> in_ready[k-1]);
  end

  for (genvar q = 0; q < NUM_PIPES / 2; q++) begin : g_pair
    // R4
    gang_pair_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
      pipe_gang[2*q+1] |-> (pipe_gang[2*q] && pipe_issue[2*q] && pipe_issue[2*q+1] &&
        pipe_id[(2*q)*ID_W +: ID_W] == pipe_id[(2*q+1)*ID_W +: ID_W] &&
        pipe_slot_base[4*q+2 +: 2] == 2'd2));
    // R6
    gang_align_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
      pipe_gang[2*q] |-> pipe_gang[2*q+1]);
  end

  // R5
  ready_valid_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_ready & ~in_valid) == '0);

  // R8
  pass2_block_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    pend_q |-> in_ready == '0);

  // R8
  pass2_issue_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    pend_q |=> (pipe_issue[0] && !pipe_gang[0] && pipe_slot_base[1:0] == 2'd2 &&
                busy_cnt == CNT_W'(1)));

  // R7
  legacy_no_gang_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !gang_en |=> (pipe_gang == '0));

  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rst_sync_n |-> (in_ready == '0));

endmodule

// File: tb/frag_dispatch_test.sv
`timescale 1ns/1ps
module frag_dispatch_test;

  localparam int NP  = 4;
  localparam int IDW = 8;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            gang_en;
  logic [NP-1:0]   in_valid;
  logic [NP-1:0]   in_ready;
  logic [NP*IDW-1:0] in_id;
  logic [NP*3-1:0] in_tex;
  logic [NP-1:0]   pipe_issue;
  logic [NP*IDW-1:0] pipe_id;
  logic [NP-1:0]   pipe_gang;
  logic [NP*2-1:0] pipe_slot_base;
  logic [NP*2-1:0] pipe_slot_num;
  logic [2:0]      frag_cnt;
  logic [2:0]      busy_cnt;

  always #4 clk = ~clk;

  frag_dispatch #(.NUM_PIPES(NP), .ID_W(IDW)) uut (
    .clk(clk), .rst_n(rst_n), .gang_en(gang_en),
    .in_valid(in_valid), .in_ready(in_ready), .in_id(in_id), .in_tex(in_tex),
    .pipe_issue(pipe_issue), .pipe_id(pipe_id), .pipe_gang(pipe_gang),
    .pipe_slot_base(pipe_slot_base), .pipe_slot_num(pipe_slot_num),
    .frag_cnt(frag_cnt), .busy_cnt(busy_cnt)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // stimulus of the current cycle
  bit        d_gang;
  bit [3:0]  d_val;
  bit [2:0]  d_tex [NP];
  bit [7:0]  next_id = 8'h10;

  // spec model state and expectations
  bit        m_pend;
  bit [7:0]  m_pid;
  bit [1:0]  m_pnum;
  bit [3:0]  e_rdy;
  bit        e_vld  [NP];
  bit        e_gang [NP];
  bit        e_hi   [NP];
  bit [7:0]  e_id   [NP];
  bit [1:0]  e_base [NP];
  bit [1:0]  e_num  [NP];
  string     e_tag  [NP];

  task automatic chk(input bit ok, input string tag, input string msg);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s", tag, msg);
    end
  endtask

  task automatic place(input int p, input bit [7:0] id, input bit g, input bit hi,
                       input bit [1:0] b, input bit [1:0] n, input string tag);
    e_vld[p] = 1; e_id[p] = id; e_gang[p] = g; e_hi[p] = hi;
    e_base[p] = b; e_num[p] = n; e_tag[p] = tag;
  endtask

  // computes what the requirements demand for the current inputs
  task automatic model_step();
    int  nf;
    bit  stop;
    int  c;
    int  s;
    bit  clampd;
    bit [7:0] id;
    nf = 0; stop = 0; e_rdy = '0;
    for (int p = 0; p < NP; p++) begin
      e_vld[p] = 0; e_gang[p] = 0; e_hi[p] = 0; e_id[p] = 0;
      e_base[p] = 0; e_num[p] = 0; e_tag[p] = "R9";
    end
    if (m_pend) begin
      place(0, m_pid, 0, 0, 2'd2, m_pnum, "R8");
      stop = 1; m_pend = 0;
    end
    for (int k = 0; k < NP; k++) begin
      clampd = (d_tex[k] == 0) || (d_tex[k] > 4);
      c  = (d_tex[k] == 0) ? 1 : (d_tex[k] > 4) ? 4 : int'(d_tex[k]);
      id = in_id[k*IDW +: IDW];
      if (stop || !d_val[k]) stop = 1;
      else if (c <= 2) begin
        if (nf < NP) begin
          place(nf, id, 0, 0, 2'd0, 2'(c), clampd ? "R2" : "R3");
          nf++; e_rdy[k] = 1;
        end else stop = 1;
      end else if (d_gang) begin
        s = (nf % 2 == 1) ? nf + 1 : nf;
        if (s + 1 < NP) begin
          place(s,     id, 1, 0, 2'd0, 2'd2,    clampd ? "R2" : (s != nf) ? "R6" : "R4");
          place(s + 1, id, 1, 1, 2'd2, 2'(c-2), clampd ? "R2" : (s != nf) ? "R6" : "R4");
          nf = s + 2; e_rdy[k] = 1;
        end else stop = 1;
      end else begin
        if (nf < NP) begin
          place(nf, id, 0, 0, 2'd0, 2'd2, clampd ? "R2" : "R7");
          m_pend = 1; m_pid = id; m_pnum = 2'(c - 2);
          e_rdy[k] = 1; stop = 1;
        end else stop = 1;
      end
    end
  endtask

  task automatic check_outputs();
    int ef, eb;
    ef = 0; eb = 0;
    for (int p = 0; p < NP; p++) begin
      bit ok;
      // R9: expectation from the previous cycle's acceptance, visible for one cycle only
      ok = (pipe_issue[p] == e_vld[p]);
      if (e_vld[p])
        ok = ok && pipe_id[p*IDW +: IDW] == e_id[p] && pipe_gang[p] == e_gang[p] &&
             pipe_slot_base[2*p +: 2] == e_base[p] && pipe_slot_num[2*p +: 2] == e_num[p];
      chk(ok, e_tag[p], $sformatf("pipe%0d got v%0b id%0h g%0b b%0d n%0d exp v%0b id%0h g%0b b%0d n%0d",
          p, pipe_issue[p], pipe_id[p*IDW +: IDW], pipe_gang[p], pipe_slot_base[2*p +: 2],
          pipe_slot_num[2*p +: 2], e_vld[p], e_id[p], e_gang[p], e_base[p], e_num[p]));
      eb += int'(e_vld[p]);
      ef += int'(e_vld[p] && !e_hi[p]);
    end
    // R10 counts; R11 when all pipes are busy
    chk(int'(frag_cnt) == ef && int'(busy_cnt) == eb, (eb == NP) ? "R11" : "R10",
        $sformatf("counts got frag%0d busy%0d exp frag%0d busy%0d", frag_cnt, busy_cnt, ef, eb));
  endtask

  task automatic run_cycle();
    string rtag;
    @(negedge clk);
    check_outputs();
    gang_en  = d_gang;
    in_valid = d_val;
    for (int k = 0; k < NP; k++) begin
      in_tex[k*3 +: 3]     = d_tex[k];
      in_id[k*IDW +: IDW]  = next_id + 8'(k);
    end
    #1;
    rtag = m_pend ? "R8" : "R5";
    model_step();
    chk(in_ready == e_rdy, rtag, $sformatf("in_ready got %b exp %b", in_ready, e_rdy));
    next_id = next_id + 8'd4;
  endtask

  task automatic set_lanes(input bit g, input bit [3:0] v,
                           input bit [2:0] t0, input bit [2:0] t1,
                           input bit [2:0] t2, input bit [2:0] t3);
    d_gang = g; d_val = v;
    d_tex[0] = t0; d_tex[1] = t1; d_tex[2] = t2; d_tex[3] = t3;
    run_cycle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; gang_en = 1'b1; in_valid = '1; in_id = '0; in_tex = '0;
    m_pend = 0;
    for (int p = 0; p < NP; p++) begin
      e_vld[p] = 0; e_hi[p] = 0; e_gang[p] = 0; e_id[p] = 0;
      e_base[p] = 0; e_num[p] = 0; e_tag[p] = "R9";
    end
    repeat (3) @(negedge clk);
    // R1: quiet under reset even with all lanes valid
    chk(pipe_issue == '0 && frag_cnt == 0 && busy_cnt == 0 && in_ready == '0, "R1",
        $sformatf("reset got issue%b frag%0d busy%0d rdy%b exp 0", pipe_issue, frag_cnt, busy_cnt, in_ready));
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: still quiet during the synchronised release
    chk(in_ready == '0, "R1", $sformatf("release rdy got %b exp 0000", in_ready));
    in_valid = '0;
    repeat (4) @(negedge clk);

    // directed corners
    set_lanes(1, 4'b1111, 1, 2, 1, 2);   // R11 four singles
    set_lanes(1, 4'b1111, 4, 4, 4, 4);   // R11 two pairs, lanes 2-3 refused
    set_lanes(1, 4'b0011, 1, 4, 0, 0);   // R6 pair shifted to 2-3
    set_lanes(1, 4'b1111, 1, 1, 1, 4);   // R5 pair does not fit
    set_lanes(1, 4'b1111, 0, 7, 5, 6);   // R2 clamp values
    set_lanes(1, 4'b1011, 2, 3, 1, 1);   // R5 gap stops lane 3
    set_lanes(0, 4'b1111, 4, 1, 1, 1);   // R7 legacy first pass
    set_lanes(0, 4'b1111, 1, 1, 1, 1);   // R8 second pass, nothing accepted
    set_lanes(0, 4'b0111, 1, 3, 1, 1);   // R7 after a single
    set_lanes(1, 4'b1111, 4, 4, 1, 1);   // R8 pending completes despite mode change
    set_lanes(1, 4'b0000, 0, 0, 0, 0);
    set_lanes(1, 4'b0000, 0, 0, 0, 0);

    // constrained random
    for (int i = 0; i < 1500; i++) begin
      bit [3:0] v;
      int len;
      if ($urandom % 4 != 0) begin
        len = $urandom % 5;
        v = 4'((1 << len) - 1);
      end else v = 4'($urandom);
      d_gang = ($urandom % 4) != 0;
      d_val  = v;
      for (int k = 0; k < NP; k++)
        d_tex[k] = ($urandom % 10 < 8) ? 3'(1 + $urandom % 4) : 3'($urandom % 8);
      run_cycle();
    end
    d_val = '0;
    run_cycle();
    run_cycle();

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule